// File: doc/BRIEF.md
# Block-Transfer Serial Configuration Slave

This block is the two-wire serial configuration port of a clock generator. It holds a small bank of 8-bit configuration registers and presents them in parallel to the clock logic. It takes the SCL and SDA lines as plain inputs, oversamples them with a fast system clock, and pulls SDA low through an open-drain enable when it acknowledges or sends a zero bit.

Writes are block-only. After the device address, the host sends two bytes (a command byte and a count byte). The slave acknowledges both and throws them away. The data bytes that follow fill the registers strictly upward from register 0. The host may issue STOP after any whole byte, and every register written before that point keeps its new value.

Reads return a fixed count byte first, then every register in index order. There is no way to address a single register.

Top module: `blkcfg_slave`

## Requirements
- R1: After reset, register 0 reads 8'h00 and registers 1 to NREG-1 read 8'hFF. Register k appears on cfg_o[8k+7:8k], and sda_oe is low.
- R2: The slave answers only the 7-bit address 7'h69, which is 8'hD2 for a write and 8'hD3 for a read, with the R/W bit (1 = read) as the LSB. It acknowledges a matching address by driving SDA low in the ninth clock. For any other address it leaves SDA released.
- R3: In a write, the slave acknowledges the first two bytes after the address and changes no register because of them.
- R4: In a write, the slave acknowledges data bytes 3 onward and stores them MSB first into registers 0, 1, 2 and so on, in arrival order.
- R5: A STOP after any whole byte ends the write. Registers already written keep their new values, and all other registers keep their old values.
- R6: Write data bytes beyond register NREG-1 are acknowledged but not stored.
- R7: A read sends NREG (8'h06) as the first byte, then registers 0 to NREG-1, each MSB first. The slave continues only while the host acknowledges.
- R8: In a read, any byte requested after the last register reads 8'hFF.
- R9: After the slave gets a host NACK in a read, or after an unmatched address, it keeps SDA released. It acknowledges nothing more and stores nothing until the next START.
- R10: A START is an SDA fall while SCL is high, and a STOP is an SDA rise while SCL is high. A repeated START restarts the byte sequence, so the next write data byte goes to register 0 and the next read begins with the count byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| cfg_o | output | 8*NREG | Configuration registers, register k on bits 8k+7:8k |

## Verification
The bench uses the default parameters: six registers, address 7'h69, and the reset pattern of a zero register 0 with all-ones enable registers. Because the register count is small, a single transfer can run past the last register. That reaches both boundary cases, the dropped ninth write byte and the 8'hFF read-back beyond the end. A behavioural register image is checked against cfg_o in every low phase of SCL, so the check also catches a register that changes in response to discarded command bytes, an unmatched address, a bus after NACK, or a partial write.

// File: rtl/blkcfg_slave.sv
module blkcfg_slave #(
  parameter int NREG = 6,
  parameter logic [6:0] DEV_ADDR = 7'h69,
  parameter logic [NREG*8-1:0] RST_VAL = {{(NREG-1){8'hFF}}, 8'h00}
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  output logic [NREG*8-1:0] cfg_o
);
  localparam int CW = $clog2(NREG + 3);
  localparam logic [CW-1:0] SAT = CW'(NREG + 2);

  typedef enum logic [2:0] {S_IDLE, S_RX, S_HOLD, S_ACK, S_TX, S_MACK, S_WAIT} st_t;

  st_t st;
  logic [2:0] scl_p, sda_p, bitc;
  logic [7:0] sr, txbyte;
  logic [CW-1:0] cnt;
  logic is_addr, rw, nack, mack;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_p <= '1;
      sda_p <= '1;
    end else begin
      scl_p <= {scl_p[1:0], scl_i};
      sda_p <= {sda_p[1:0], sda_i};
    end

  wire start_det = scl_p[1] & scl_p[2] & sda_p[2] & ~sda_p[1];
  wire stop_det  = scl_p[1] & scl_p[2] & ~sda_p[2] & sda_p[1];
  wire rise      = scl_p[1] & ~scl_p[2];
  wire fall      = ~scl_p[1] & scl_p[2];
  wire [7:0] byte_in = {sr[6:0], sda_p[1]};
  wire rx_done   = (st == S_RX) && rise && (bitc == 3'd7);
  wire we        = rx_done && !is_addr && !rw && (cnt >= CW'(2)) && (cnt < SAT);
  wire [CW-1:0] widx = cnt - CW'(2);

  always_comb begin
    txbyte = 8'hFF;
    if (cnt == '0) txbyte = 8'(NREG);
    else if (cnt <= CW'(NREG)) txbyte = cfg_o[(32'(cnt) - 1) * 8 +: 8];
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= S_IDLE; bitc <= '0; sr <= '0; cnt <= '0;
      is_addr <= 1'b0; rw <= 1'b0; nack <= 1'b0; mack <= 1'b0;
    end else if (start_det) begin
      st <= S_RX; bitc <= '0; is_addr <= 1'b1; cnt <= '0;
    end else if (stop_det) begin
      st <= S_IDLE;
    end else begin
      case (st)
        S_RX: if (rise) begin
          sr <= byte_in;
          bitc <= bitc + 3'd1;
          if (bitc == 3'd7) begin
            st <= S_HOLD;
            is_addr <= 1'b0;
            if (is_addr) begin
              rw <= byte_in[0];
              nack <= byte_in[7:1] != DEV_ADDR;
            end else begin
              nack <= 1'b0;
              if (cnt != SAT) cnt <= cnt + CW'(1);
            end
          end
        end
        S_HOLD: if (fall) st <= nack ? S_WAIT : S_ACK;
        S_ACK: if (fall) begin
          bitc <= '0;
          if (rw) begin
            st <= S_TX; sr <= txbyte;
            if (cnt != SAT) cnt <= cnt + CW'(1);
          end else st <= S_RX;
        end
        S_TX: if (fall) begin
          if (bitc == 3'd7) st <= S_MACK;
          else begin
            sr <= {sr[6:0], 1'b1};
            bitc <= bitc + 3'd1;
          end
        end
        S_MACK: begin
          if (rise) mack <= ~sda_p[1];
          if (fall) begin
            if (mack) begin
              st <= S_TX; sr <= txbyte; bitc <= '0;
              if (cnt != SAT) cnt <= cnt + CW'(1);
            end else st <= S_WAIT;
          end
        end
        default: ;
      endcase
    end

  for (genvar k = 0; k < NREG; k++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) cfg_o[k*8 +: 8] <= RST_VAL[k*8 +: 8];
      else if (we && widx == CW'(k)) cfg_o[k*8 +: 8] <= byte_in;
  end

  assign sda_oe = (st == S_ACK) || (st == S_TX && !sr[7]);

  p_reset_default_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (cfg_o == RST_VAL && !sda_oe));
  p_store_only_on_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(cfg_o));
  p_index_in_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> (widx < CW'(NREG)));
  p_quiet_after_nack_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WAIT) |-> !sda_oe);
  p_release_on_stop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_oe);
  p_drive_only_ack_or_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sda_oe |-> (st == S_ACK || (st == S_TX && rw)));
endmodule

// File: tb/blkcfg_slave_bench.sv
module blkcfg_slave_bench;
  localparam int CLK_NS = 10;
  localparam int H = 16;
  localparam int Q = 4;
  localparam int NREG = 6;

  logic clk = 0, rst_n = 0, scl_m = 1, m_low = 0, run_cmp = 0;
  logic sda_oe, sda;
  logic [NREG*8-1:0] cfg_o;
  logic [7:0] expr [NREG];
  int vectors = 0, errors = 0;
  string cur_req = "R1";

  always #(CLK_NS/2) clk = ~clk;
  assign sda = ~(m_low | sda_oe);

  blkcfg_slave u_blkcfg_slave (.clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda),
                               .sda_oe(sda_oe), .cfg_o(cfg_o));

  always @(negedge clk)
    if (rst_n && run_cmp && !scl_m)
      for (int k = 0; k < NREG; k++) begin
        vectors++;
        if (cfg_o[k*8 +: 8] !== expr[k]) begin
          errors++;
          $display("FAIL %s reg%0d actual %h expected %h", cur_req, k, cfg_o[k*8 +: 8], expr[k]);
        end
      end

  task automatic chk(input string req, input int act, input int expv);
    vectors++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, expv);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic bus_start;
    m_low = 0; scl_m = 1; tick(H); m_low = 1; tick(H); scl_m = 0; tick(Q);
  endtask
  task automatic bus_rstart;
    m_low = 0; tick(H); scl_m = 1; tick(H); m_low = 1; tick(H); scl_m = 0; tick(Q);
  endtask
  task automatic bus_stop;
    m_low = 1; tick(H); scl_m = 1; tick(H); m_low = 0; tick(H);
  endtask

  task automatic put_byte(input logic [7:0] b, input int sidx, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      m_low = ~b[i]; tick(H); scl_m = 1;
      if (i == 0 && sidx >= 0 && sidx < NREG) expr[sidx] = b;
      tick(H); scl_m = 0; tick(Q);
    end
    m_low = 0; tick(H); scl_m = 1; tick(H/2); ack = ~sda; tick(H/2); scl_m = 0; tick(Q);
  endtask

  task automatic get_byte(output logic [7:0] b, input logic ack);
    for (int i = 7; i >= 0; i--) begin
      tick(H); scl_m = 1; tick(H/2); b[i] = sda; tick(H/2); scl_m = 0; tick(Q);
    end
    m_low = ack; tick(H); scl_m = 1; tick(H); scl_m = 0; tick(Q); m_low = 0;
  endtask

  task automatic write_seq(input logic [7:0] q[$], input logic do_start);
    logic a;
    if (do_start) bus_start;
    put_byte(8'hD2, -1, a); chk("R2 write address ack", a, 1);
    cur_req = "R3";
    put_byte(8'h5A, -1, a); chk("R3 command ack", a, 1);
    put_byte(8'hC3, -1, a); chk("R3 count ack", a, 1);
    cur_req = "R4";
    foreach (q[i]) begin
      put_byte(q[i], i, a);
      chk(i < NREG ? "R4 data ack" : "R6 extra data ack", a, 1);
    end
  endtask

  task automatic read_seq(input int n, input logic do_start);
    logic a;
    logic [7:0] b;
    if (do_start) bus_start;
    put_byte(8'hD3, -1, a); chk("R2 read address ack", a, 1);
    get_byte(b, n > 0); chk("R7 count byte", b, NREG);
    for (int i = 0; i < n; i++) begin
      get_byte(b, i < n - 1);
      if (i < NREG) chk("R7 register read", b, expr[i]);
      else chk("R8 past-end read", b, 8'hFF);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    logic a;
    logic [7:0] b;
    expr[0] = 8'h00;
    for (int k = 1; k < NREG; k++) expr[k] = 8'hFF;
    tick(5); rst_n = 1; tick(5);
    chk("R1 reset value", cfg_o, {{(NREG-1){8'hFF}}, 8'h00});
    chk("R1 sda released", sda_oe, 0);
    run_cmp = 1;

    cur_req = "R4";
    write_seq('{8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66}, 1); bus_stop;

    cur_req = "R5";
    write_seq('{8'hA1, 8'hB2}, 1); bus_stop;
    chk("R5 untouched reg2", cfg_o[23:16], 8'h33);

    write_seq('{8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06, 8'hE7, 8'hE8}, 1); bus_stop;
    chk("R6 last reg kept", cfg_o[47:40], 8'h06);

    read_seq(NREG, 1); bus_stop;
    read_seq(NREG + 2, 1); bus_stop;

    cur_req = "R9";
    bus_start;
    put_byte(8'hA0, -1, a); chk("R2 foreign address nack", a, 0);
    put_byte(8'h00, -1, a); chk("R9 ignored after bad address", a, 0);
    bus_stop;

    read_seq(0, 1);
    get_byte(b, 1'b0); chk("R9 released after host nack", b, 8'hFF);
    bus_stop;

    cur_req = "R10";
    write_seq('{8'h9C}, 1);
    bus_rstart;
    write_seq('{8'h7E, 8'h6D}, 0);
    chk("R10 restart to reg0", cfg_o[7:0], 8'h7E);
    bus_rstart;
    read_seq(3, 0); bus_stop;

    tick(H);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule